// File: doc/BRIEF.md
# Timestamped Event Trace Buffer

This block collects trace events from a set of hardware event inputs and from a processor write port, and turns them into a single stream of fixed-width records. Every record carries a trace-point identifier, a start/stop marker, a bit naming the source and a timestamp. All timestamps come from one shared counter. The counter stays at zero after reset. It begins counting on the first accepted event and then runs without stopping.

Records go into an on-chip FIFO, and a host-side reader empties it through a valid/ready read port while capture continues. The reader may be far slower than the producers. When the FIFO is full, new records are thrown away and the records already stored are kept. The first such loss raises an overflow flag that stays set until the next reset. The reader can see the current fill count and the flag at all times.

Top module: `trace_capture_buf`

## Requirements
- R1: Hardware and software events share one FIFO. A record packs the identifier in bits [ID_W-1:0] and the marker in bit ID_W (1 = start, 0 = stop). Bit ID_W+1 gives the source (1 = hardware input, 0 = software port), and the timestamp fills bits [ID_W+TS_W+1:ID_W+2].
- R2: The timestamp counter holds zero after reset. The first record accepted into arbitration gets timestamp 0. A record accepted k clock edges later gets k modulo 2^TS_W, so the stamp wraps without notice.
- R3: At most one record is accepted per cycle. Pending hardware events win over software, and among them the lowest input index wins.
- R4: Each hardware input has one pending slot. A pulse on `hw_evt_valid[i]` is captured at the clock edge and can be accepted in the following cycle at the earliest. A pulse on an input whose slot is full, and is not being granted in that cycle, is discarded.
- R5: `sw_wr_ready` is high exactly when no hardware event is pending. A software record is accepted at the edge where `sw_wr_en` and `sw_wr_ready` are both high. An accepted software record enters the FIFO at that same edge.
- R6: `rd_valid` is high while the FIFO holds a record, and `rd_data` shows the oldest record. The record is removed at an edge where `rd_valid` and `rd_ready` are both high. While it is not removed, `rd_data` stays unchanged.
- R7: A record accepted while the fill count equals DEPTH is dropped, even if a read happens in the same cycle. Stored records are left intact.
- R8: The first dropped record sets `stat_overflow`. The flag stays set until `rst_n` is asserted, and reads and writes do not clear it.
- R9: `stat_fill` gives the number of stored records and never exceeds DEPTH. After reset the FIFO is empty, `stat_overflow` is 0 and `sw_wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the only way to clear the flag and the counter |
| hw_evt_valid | input | NUM_HW | One-cycle event pulse per hardware input |
| hw_evt_id | input | NUM_HW*ID_W | Trace-point identifier per input, input i at bits [i*ID_W +: ID_W] |
| hw_evt_kind | input | NUM_HW | Start (1) or stop (0) per input |
| sw_wr_en | input | 1 | Software write request, held until accepted |
| sw_wr_id | input | ID_W | Software trace-point identifier |
| sw_wr_kind | input | 1 | Software start (1) or stop (0) |
| sw_wr_ready | output | 1 | High when a software write is accepted at the next edge |
| rd_valid | output | 1 | FIFO holds a record |
| rd_ready | input | 1 | Reader takes the head record |
| rd_data | output | ID_W+TS_W+2 | Oldest record |
| stat_fill | output | clog2(DEPTH+1) | Number of stored records |
| stat_overflow | output | 1 | Sticky overflow flag |

## Verification
A wrong pending slot or a wrong arbiter choice shows up at the read port a cycle or two after the pulses. It appears as records out of priority order, a missing or duplicated identifier, or a software record that gets in while a hardware slot is still held. A counter that started early, stopped or skipped shows as a wrong timestamp on the next record read out. A pointer or count error shows as the wrong head record, or as a fill count that disagrees with the number of writes minus reads. A drop check that looks at the wrong count shows within one cycle as a lost record or a stray overflow flag.

// File: rtl/trace_pkg.sv
`timescale 1ns/1ps
package trace_pkg;
  typedef enum logic {SRC_SW = 1'b0, SRC_HW = 1'b1} trc_src_e;
  typedef enum logic {KIND_STOP = 1'b0, KIND_START = 1'b1} trc_kind_e;
endpackage

// File: rtl/trace_src_arb.sv
`timescale 1ns/1ps
module trace_src_arb #(
  parameter int NUM_HW = 4,
  parameter int ID_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_HW-1:0]      hw_evt_valid,
  input  logic [NUM_HW*ID_W-1:0] hw_evt_id,
  input  logic [NUM_HW-1:0]      hw_evt_kind,
  input  logic                   sw_wr_en,
  input  logic [ID_W-1:0]        sw_wr_id,
  input  logic                   sw_wr_kind,
  output logic                   sw_wr_ready,
  output logic [NUM_HW:0]        grant,
  output logic                   sel_valid,
  output logic [ID_W-1:0]        sel_id,
  output logic                   sel_kind,
  output logic                   sel_src
);
  import trace_pkg::*;

  logic            pend_q [NUM_HW];
  logic [ID_W-1:0] id_q   [NUM_HW];
  logic            kind_q [NUM_HW];
  logic [NUM_HW-1:0] pend_vec;

  // one pending slot per hardware input
  for (genvar i = 0; i < NUM_HW; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        id_q[i]   <= '0;
        kind_q[i] <= 1'b0;
      end else if (hw_evt_valid[i] && (!pend_q[i] || grant[i])) begin
        pend_q[i] <= 1'b1;
        id_q[i]   <= hw_evt_id[i*ID_W +: ID_W];
        kind_q[i] <= hw_evt_kind[i];
      end else if (grant[i]) begin
        pend_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_HW; i++) pend_vec[i] = pend_q[i];
  end

  // fixed priority: lowest hardware index first, software last
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_HW; i++) begin
      if (pend_vec[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    sw_wr_ready   = ~(|pend_vec);
    grant[NUM_HW] = sw_wr_en && sw_wr_ready;
  end

  always_comb begin
    sel_id   = '0;
    sel_kind = 1'b0;
    sel_src  = SRC_SW;
    for (int i = 0; i < NUM_HW; i++) begin
      if (grant[i]) begin
        sel_id   = id_q[i];
        sel_kind = kind_q[i];
        sel_src  = SRC_HW;
      end
    end
    if (grant[NUM_HW]) begin
      sel_id   = sw_wr_id;
      sel_kind = sw_wr_kind;
      sel_src  = SRC_SW;
    end
  end

  assign sel_valid = |grant;
endmodule

// File: rtl/trace_tstamp.sv
`timescale 1ns/1ps
module trace_tstamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            first_evt,
  output logic            running,
  output logic [TS_W-1:0] stamp
);
  logic [TS_W-1:0] cnt_q;
  logic            run_q;

  // idle until the first accepted event, then free-running forever
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (first_evt) begin
      run_q <= 1'b1;
      cnt_q <= TS_W'(1);
    end
  end

  assign running = run_q;
  assign stamp   = cnt_q;
endmodule

// File: rtl/trace_rec_fifo.sv
`timescale 1ns/1ps
module trace_rec_fifo #(
  parameter int W     = 50,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic          full,
  output logic          not_empty,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] fill
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign full      = (cnt_q == FULL_CNT);
  assign not_empty = (cnt_q != '0);
  assign do_wr     = push && !full;
  assign do_rd     = pop && not_empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout = mem[rd_ptr];
  assign fill = cnt_q;
endmodule

// File: rtl/trace_capture_buf.sv
`timescale 1ns/1ps
module trace_capture_buf #(
  parameter int NUM_HW = 4,
  parameter int ID_W   = 16,
  parameter int TS_W   = 32,
  parameter int DEPTH  = 1024
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_HW-1:0]           hw_evt_valid,
  input  logic [NUM_HW*ID_W-1:0]      hw_evt_id,
  input  logic [NUM_HW-1:0]           hw_evt_kind,
  input  logic                        sw_wr_en,
  input  logic [ID_W-1:0]             sw_wr_id,
  input  logic                        sw_wr_kind,
  output logic                        sw_wr_ready,
  output logic                        rd_valid,
  input  logic                        rd_ready,
  output logic [ID_W+TS_W+1:0]        rd_data,
  output logic [$clog2(DEPTH+1)-1:0]  stat_fill,
  output logic                        stat_overflow
);
  localparam int REC_W = ID_W + TS_W + 2;
  localparam int CW    = $clog2(DEPTH+1);

  function automatic logic [REC_W-1:0] make_rec(
    input logic [TS_W-1:0] ts, input logic src,
    input logic kind, input logic [ID_W-1:0] id);
    return {ts, src, kind, id};
  endfunction

  // named internal events
  logic [NUM_HW:0]   arb_grant;
  logic              rec_valid;
  logic [ID_W-1:0]   rec_id;
  logic              rec_kind, rec_src;
  logic              ts_run;
  logic [TS_W-1:0]   ts_val;
  logic              fifo_full;
  logic              rec_drop;
  logic              ovf_q;

  trace_src_arb #(.NUM_HW(NUM_HW), .ID_W(ID_W)) arb_i (
    .clk(clk), .rst_n(rst_n),
    .hw_evt_valid(hw_evt_valid), .hw_evt_id(hw_evt_id), .hw_evt_kind(hw_evt_kind),
    .sw_wr_en(sw_wr_en), .sw_wr_id(sw_wr_id), .sw_wr_kind(sw_wr_kind),
    .sw_wr_ready(sw_wr_ready), .grant(arb_grant),
    .sel_valid(rec_valid), .sel_id(rec_id), .sel_kind(rec_kind), .sel_src(rec_src)
  );

  trace_tstamp #(.TS_W(TS_W)) ts_i (
    .clk(clk), .rst_n(rst_n), .first_evt(rec_valid),
    .running(ts_run), .stamp(ts_val)
  );

  trace_rec_fifo #(.W(REC_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(rec_valid), .din(make_rec(ts_val, rec_src, rec_kind, rec_id)),
    .pop(rd_ready), .full(fifo_full), .not_empty(rd_valid),
    .dout(rd_data), .fill(stat_fill)
  );

  assign rec_drop = rec_valid && fifo_full;

  // sticky overflow, cleared only by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_q <= 1'b0;
    else if (rec_drop) ovf_q <= 1'b1;
  end

  assign stat_overflow = ovf_q;
endmodule

// File: rtl/trace_capture_chk.sv
`timescale 1ns/1ps
module trace_capture_chk #(
  parameter int NUM_HW = 4,
  parameter int TS_W   = 32,
  parameter int DEPTH  = 1024,
  parameter int REC_W  = 50,
  parameter int CW     = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NUM_HW:0]  grant,
  input logic             drop,
  input logic             ts_run,
  input logic [TS_W-1:0]  ts_val,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [REC_W-1:0] rd_data,
  input logic [CW-1:0]    stat_fill,
  input logic             stat_overflow
);
  a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_ts_increments: assert property (@(posedge clk) disable iff (!rst_n)
    ts_run |=> (ts_run && ts_val == $past(ts_val) + 1'b1));

  a_r6_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  a_r7_drop_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (stat_fill == CW'(DEPTH)));

  a_r8_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> stat_overflow);

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stat_overflow |=> stat_overflow);

  a_r9_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stat_fill <= CW'(DEPTH));
endmodule

bind trace_capture_buf trace_capture_chk #(
  .NUM_HW(NUM_HW), .TS_W(TS_W), .DEPTH(DEPTH), .REC_W(REC_W), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .grant(arb_grant), .drop(rec_drop),
  .ts_run(ts_run), .ts_val(ts_val), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .stat_fill(stat_fill), .stat_overflow(stat_overflow)
);

// File: tb/trace_capture_buf_tb_top.sv
`timescale 1ns/1ps
module trace_capture_buf_tb_top;
  localparam int NH = 4, IW = 16, TW = 8, DP = 8;
  localparam int RW = IW + TW + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NH-1:0]    hw_evt_valid = '0;
  logic [NH*IW-1:0] hw_evt_id = '0;
  logic [NH-1:0]    hw_evt_kind = '0;
  logic             sw_wr_en = 1'b0, sw_wr_kind = 1'b0, rd_ready = 1'b0;
  logic [IW-1:0]    sw_wr_id = '0;
  logic             sw_wr_ready, rd_valid, stat_overflow;
  logic [RW-1:0]    rd_data;
  logic [3:0]       stat_fill;

  int n_run = 0, n_fail = 0, cyc = 0, first_edge = 0;
  bit done = 1'b0;

  trace_capture_buf #(.NUM_HW(NH), .ID_W(IW), .TS_W(TW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_evt_valid(hw_evt_valid), .hw_evt_id(hw_evt_id),
    .hw_evt_kind(hw_evt_kind), .sw_wr_en(sw_wr_en), .sw_wr_id(sw_wr_id),
    .sw_wr_kind(sw_wr_kind), .sw_wr_ready(sw_wr_ready), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .stat_fill(stat_fill),
    .stat_overflow(stat_overflow)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] rec(input int edge_n, input logic src,
                                        input logic kind, input logic [IW-1:0] id);
    logic [TW-1:0] ts;
    ts = TW'((edge_n - first_edge) % (1 << TW));
    return {ts, src, kind, id};
  endfunction

  task automatic sw_write(input logic [IW-1:0] id, input logic kind, output int acc);
    sw_wr_en = 1'b1; sw_wr_id = id; sw_wr_kind = kind;
    while (!sw_wr_ready) tick();
    tick();
    acc = cyc;
    sw_wr_en = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input logic [RW-1:0] exp);
    chk({tag, " valid"}, 64'(rd_valid), 64'd1);
    chk(tag, 64'(rd_data), 64'(exp));
    rd_ready = 1'b1; tick(); rd_ready = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++; n_run++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int e, a;
    int accs [DP];
    tick(); tick(); rst_n = 1'b1; tick();
    // R9 reset state
    chk("R9 reset fill", 64'(stat_fill), 64'd0);
    chk("R9 reset valid", 64'(rd_valid), 64'd0);
    chk("R9 reset ovf", 64'(stat_overflow), 64'd0);
    chk("R9 reset ready", 64'(sw_wr_ready), 64'd1);

    // R2 counter idle: first record after a long idle has stamp 0
    repeat (20) tick();
    sw_write(16'h1234, 1'b1, a);
    first_edge = a;
    chk("R9 fill one", 64'(stat_fill), 64'd1);
    pop_chk("R2 first stamp zero R1 layout", {8'h00, 1'b0, 1'b1, 16'h1234});
    repeat (7) tick();
    sw_write(16'h00AB, 1'b0, a);
    pop_chk("R2 stamp counts edges", rec(a, 1'b0, 1'b0, 16'h00AB));

    // R3 R5 all hardware inputs plus software at once
    for (int i = 0; i < NH; i++) begin
      hw_evt_id[i*IW +: IW] = IW'(16'h0100 + i);
      hw_evt_kind[i] = 1'(i);
    end
    hw_evt_valid = '1; e = cyc; tick(); hw_evt_valid = '0;
    chk("R5 ready low while pending", 64'(sw_wr_ready), 64'd0);
    sw_write(16'h0055, 1'b0, a);
    chk("R5 sw accepted after hw drained", 64'(a), 64'(e + 2 + NH));
    for (int i = 0; i < NH; i++)
      pop_chk("R3 priority order", rec(e + 2 + i, 1'b1, 1'(i), IW'(16'h0100 + i)));
    pop_chk("R5 sw last", rec(a, 1'b0, 1'b0, 16'h0055));
    chk("R6 empty after drain", 64'(rd_valid), 64'd0);

    // R4 pulse on a still-pending input is discarded
    hw_evt_id[2*IW +: IW] = 16'h0200; hw_evt_id[3*IW +: IW] = 16'h0300;
    hw_evt_kind = '0;
    hw_evt_valid = 4'b1100; e = cyc; tick();
    hw_evt_valid = 4'b1000; hw_evt_id[3*IW +: IW] = 16'h03FF; tick();
    hw_evt_valid = '0; tick(); tick(); tick();
    chk("R4 only two records", 64'(stat_fill), 64'd2);
    pop_chk("R4 first", rec(e + 2, 1'b1, 1'b0, 16'h0200));
    pop_chk("R4 held id kept", rec(e + 3, 1'b1, 1'b0, 16'h0300));
    chk("R4 nothing extra", 64'(rd_valid), 64'd0);

    // R7 R8 fill to full, overflow, drain
    for (int k = 0; k < DP; k++) sw_write(IW'(k), 1'(k), accs[k]);
    chk("R9 full fill", 64'(stat_fill), 64'(DP));
    chk("R8 no ovf at full", 64'(stat_overflow), 64'd0);
    // R6 head holds while not read
    tick(); tick();
    chk("R6 head held", 64'(rd_data), 64'(rec(accs[0], 1'b0, 1'b0, 16'h0000)));
    for (int k = 0; k < 3; k++) sw_write(IW'(16'h00F0 + k), 1'b1, a);
    chk("R7 fill stays full", 64'(stat_fill), 64'(DP));
    chk("R8 ovf set", 64'(stat_overflow), 64'd1);
    // R7 push with concurrent pop at full is still dropped
    sw_wr_en = 1'b1; sw_wr_id = 16'h0EEE; rd_ready = 1'b1; tick();
    sw_wr_en = 1'b0; rd_ready = 1'b0;
    chk("R7 drop with pop", 64'(stat_fill), 64'(DP - 1));
    for (int k = 1; k < DP; k++)
      pop_chk("R7 oldest kept in order", rec(accs[k], 1'b0, 1'(k), IW'(k)));
    chk("R7 dropped not stored", 64'(rd_valid), 64'd0);
    chk("R8 ovf sticky after drain", 64'(stat_overflow), 64'd1);

    // R2 wrap: stamp taken modulo 2^TS_W
    repeat (300) tick();
    sw_write(16'h0777, 1'b1, a);
    chk("R2 wrap stamp", 64'(rd_data[IW+2 +: TW]), 64'((a - first_edge) & 255));
    chk("R8 ovf sticky after write", 64'(stat_overflow), 64'd1);

    // R8 R9 reset clears flag and counter
    do_reset();
    chk("R8 ovf cleared by reset", 64'(stat_overflow), 64'd0);
    chk("R9 fill zero after reset", 64'(stat_fill), 64'd0);
    repeat (13) tick();
    hw_evt_id[1*IW +: IW] = 16'h0BEE; hw_evt_kind = 4'b0010;
    hw_evt_valid = 4'b0010; e = cyc; tick(); hw_evt_valid = '0; tick();
    first_edge = e + 2;
    pop_chk("R2 restart from zero R1 hw src", {8'h00, 1'b1, 1'b1, 16'h0BEE});

    finish_run();
  end
endmodule